// File: doc/BRIEF.md
# Synchronous Buck Gate Control with Cycle-by-Cycle Current Limit

This block is the digital core that sits between a PWM source and the two gate drivers of a synchronous buck stage. It turns the PWM command into a high-side enable and a complementary low-side enable, and it inserts a programmable break-before-make gap at every commanded transition. The low-side switch can be disabled with a separate enable. Two supply-good inputs gate everything: while either one is low, both gates stay off.

Two raw overcurrent comparator results come in. One watches the high-side switch (input current) and the other watches the output current. Each is ignored for a programmable blanking window after switching edges. The input-current window opens only on a PWM rising edge. The output-current window opens on both edges. An unblanked trip ends the high-side pulse at once and holds it off until the next PWM rising edge. A current-limit flag reports trips and supply readiness. After a trip it stays set through the next PWM rising edge, and it clears only after one complete fault-free PWM cycle.

The PWM, rectifier-enable and comparator inputs are resynchronised through two flops. The blanking and dead-time lengths are counted in system clock cycles.

Top module: `buck_cycle_limiter`

## Requirements
- R1: While the rectifier-enable input has been low for three clock cycles, the low-side enable is 0. The high-side enable keeps following PWM.
- R2: The two enables are never 1 together. At each commanded change, the enable that was on drops first, and both stay 0 for exactly dead_cyc+1 cycles before the other one rises. The low side rises only when the rectifier enable is high.
- R3: When either supply-good input was low at the previous clock edge, both enables are 0.
- R4: An unblanked trip from either comparator drives the high-side enable to 0 on the next clock edge. It then stays 0 while PWM remains high and is allowed again only after the next PWM rising edge.
- R5: After a trip, the low side behaves as if the PWM pulse had ended normally: it turns on after the dead-time gap when the rectifier enable is high. A trip while the high side is already off does not disturb the low-side enable.
- R6: The input-current comparator is blanked for dead-free windows of blank_cyc+1 synchronised cycles that start on each PWM rising edge. With blank_cyc=4, a comparator pulse aligned with the rising edge and lasting 5 cycles causes no trip, while one lasting 6 cycles trips. A PWM falling edge does not blank this comparator.
- R7: The output-current comparator uses the same window length, started by both PWM rising and falling edges. A trip outside the window has the same effect as in R4.
- R8: Any unblanked trip sets the limit flag on the next edge. The following PWM rising edge resumes switching with the flag still 1. The flag clears on the next rising edge only if no trip occurred since the previous rising edge; otherwise it stays 1.
- R9: The limit flag is 1 during reset and whenever a supply-good input was low at the previous edge. With both supplies good and no pending fault, it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command, high requests the high-side switch |
| sr_en | input | 1 | Rectifier enable, low keeps the low side off |
| vdd_ok | input | 1 | Main supply good |
| reg_ok | input | 1 | Logic regulator supply good |
| cmp_in_oc | input | 1 | Raw input-current (high-side) comparator, 1 = over limit |
| cmp_out_oc | input | 1 | Raw output-current comparator, 1 = over limit |
| blank_cyc | input | BLANK_W | Blanking length in clock cycles (window is this plus one) |
| dead_cyc | input | DEAD_W | Dead-time length in clock cycles (gap is this plus one) |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| lim_flag | output | 1 | Current-limit / not-ready flag |

## Verification
The properties assume that the supply-good inputs and the rectifier enable change only at the clock rate, so their effect can be tied to fixed $past offsets. They also assume that the blanking and dead-time settings stay still while switching runs. The stimulus changes every input on the falling clock edge. It changes the length registers only while PWM has been idle for many cycles. Comparator pulses are placed either inside a known blanking window or well after it, so every trip falls on a predictable cycle.

// File: rtl/bcl_pkg.sv
package bcl_pkg;
  // Inputs resynchronised together so they keep their relative alignment.
  typedef struct packed {
    logic pwm;
    logic sre;
    logic cmp_in;
    logic cmp_out;
  } sync_bus_t;

  localparam int NUM_CMP = 2;
  localparam int CMP_IN  = 0;
  localparam int CMP_OUT = 1;
endpackage

// File: rtl/bcl_sync.sv
module bcl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q, stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bcl_blank.sv
module bcl_blank #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          blanked
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          busy;

  always_comb begin
    busy   = (cnt_q != '0);
    cnt_en = start | busy;
    cnt_d  = start ? len : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // The start cycle itself is covered, then len further cycles.
  assign blanked = start | busy;
endmodule

// File: rtl/bcl_deadtime.sv
module bcl_deadtime #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_cmd,
  input  logic          sre,
  input  logic          sup_ok,
  input  logic [DW-1:0] dead_len,
  output logic          hs_en,
  output logic          ls_en
);
  logic          cmd_q;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          dcnt_en;
  logic          change, settled;
  logic          hs_d, ls_d;

  always_comb begin
    change  = hs_cmd ^ cmd_q;
    dcnt_en = change | (dcnt_q != '0);
    dcnt_d  = change ? dead_len : dcnt_q - 1'b1;
    settled = !change && (dcnt_q == '0);
    hs_d    = sup_ok & hs_cmd & settled;
    ls_d    = sup_ok & sre & ~hs_cmd & settled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      hs_en <= 1'b0;
      ls_en <= 1'b0;
    end else begin
      cmd_q <= hs_cmd;
      hs_en <= hs_d;
      ls_en <= ls_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcnt_q <= '0;
    else if (dcnt_en) dcnt_q <= dcnt_d;
  end
endmodule

// File: rtl/buck_cycle_limiter.sv
module buck_cycle_limiter
  import bcl_pkg::*;
#(
  parameter int BLANK_W     = 8,
  parameter int DEAD_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_in,
  input  logic               sr_en,
  input  logic               vdd_ok,
  input  logic               reg_ok,
  input  logic               cmp_in_oc,
  input  logic               cmp_out_oc,
  input  logic [BLANK_W-1:0] blank_cyc,
  input  logic [DEAD_W-1:0]  dead_cyc,
  output logic               hs_en,
  output logic               ls_en,
  output logic               lim_flag
);
  localparam int SYNC_W = $bits(sync_bus_t);

  sync_bus_t          raw, syn;
  logic               pwm_q;
  logic               pwm_rise, pwm_fall;
  logic               sup_ok;
  logic [NUM_CMP-1:0] cmp_s, blank_v, start_v, trip_v;
  logic               trip;
  logic               cut_q, cut_d, cut_en;
  logic               hs_cmd;
  logic               flt_q, flt_d, seen_q, seen_d, flag_d;

  always_comb begin
    raw.pwm     = pwm_in;
    raw.sre     = sr_en;
    raw.cmp_in  = cmp_in_oc;
    raw.cmp_out = cmp_out_oc;
  end

  bcl_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= syn.pwm;
  end

  always_comb begin
    pwm_rise         = syn.pwm & ~pwm_q;
    pwm_fall         = ~syn.pwm & pwm_q;
    sup_ok           = vdd_ok & reg_ok;
    cmp_s[CMP_IN]    = syn.cmp_in;
    cmp_s[CMP_OUT]   = syn.cmp_out;
    start_v[CMP_IN]  = pwm_rise;
    start_v[CMP_OUT] = pwm_rise | pwm_fall;
  end

  // One blanking timer per comparator; they differ only in their start edges.
  for (genvar k = 0; k < NUM_CMP; k++) begin : g_blank
    bcl_blank #(.CW(BLANK_W)) u_blank (
      .clk(clk), .rst_n(rst_n), .start(start_v[k]),
      .len(blank_cyc), .blanked(blank_v[k])
    );
  end

  always_comb begin
    trip_v = cmp_s & ~blank_v;
    trip   = (|trip_v) & sup_ok;
    // Pulse cut-off: set by a trip, released by the next PWM rising edge.
    cut_en = pwm_rise | trip;
    cut_d  = ~pwm_rise;
    hs_cmd = syn.pwm & ~cut_q & ~trip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cut_q <= 1'b0;
    else if (cut_en) cut_q <= cut_d;
  end

  bcl_deadtime #(.DW(DEAD_W)) u_dead (
    .clk(clk), .rst_n(rst_n), .hs_cmd(hs_cmd), .sre(syn.sre),
    .sup_ok(sup_ok), .dead_len(dead_cyc), .hs_en(hs_en), .ls_en(ls_en)
  );

  // Flag: fault pending plus "fault seen since last rising edge".
  always_comb begin
    flt_d  = flt_q;
    seen_d = seen_q;
    if (pwm_rise) begin
      if (!seen_q) flt_d = 1'b0;
      seen_d = 1'b0;
    end
    if (trip) begin
      flt_d  = 1'b1;
      seen_d = 1'b1;
    end
    flag_d = ~sup_ok | flt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q    <= 1'b0;
      seen_q   <= 1'b0;
      lim_flag <= 1'b1;
    end else begin
      flt_q    <= flt_d;
      seen_q   <= seen_d;
      lim_flag <= flag_d;
    end
  end
endmodule

// File: rtl/bcl_checker.sv
module bcl_checker (
  input logic clk,
  input logic rst_n,
  input logic sr_en,
  input logic vdd_ok,
  input logic reg_ok,
  input logic hs_en,
  input logic ls_en,
  input logic lim_flag,
  input logic trip
);
  // R1: rectifier enable low three edges back keeps the low side off
  a_r1_ls_off_without_sre: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sr_en, 3) |-> !ls_en);

  // R2: never both on
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  // R2: a gap follows every turn-off
  a_r2_gap_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> !ls_en);
  a_r2_gap_after_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_en) |-> !hs_en);

  // R3: missing supply forces both gates off
  a_r3_supply_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vdd_ok && reg_ok) |-> (!hs_en && !ls_en));

  // R4: an unblanked trip ends the high-side pulse on the next edge
  a_r4_trip_cuts_hs: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> !hs_en);

  // R8: an unblanked trip raises the flag
  a_r8_trip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> lim_flag);

  // R9: flag held while supplies are not good
  a_r9_flag_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vdd_ok && reg_ok) |-> lim_flag);
endmodule

bind buck_cycle_limiter bcl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sr_en(sr_en), .vdd_ok(vdd_ok), .reg_ok(reg_ok),
  .hs_en(hs_en), .ls_en(ls_en), .lim_flag(lim_flag), .trip(trip)
);

// File: tb/sim_buck_cycle_limiter.sv
module sim_buck_cycle_limiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0, sr_en = 1'b0, vdd_ok = 1'b0, reg_ok = 1'b0;
  logic       cmp_in_oc = 1'b0, cmp_out_oc = 1'b0;
  logic [7:0] blank_cyc = 8'd4;
  logic [5:0] dead_cyc = 6'd2;
  logic       hs_en, ls_en, lim_flag;
  int         n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  buck_cycle_limiter u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .sr_en(sr_en),
    .vdd_ok(vdd_ok), .reg_ok(reg_ok), .cmp_in_oc(cmp_in_oc),
    .cmp_out_oc(cmp_out_oc), .blank_cyc(blank_cyc), .dead_cyc(dead_cyc),
    .hs_en(hs_en), .ls_en(ls_en), .lim_flag(lim_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean_cycles();
    repeat (2) begin
      pwm_in = 1'b1; wait_cyc(20);
      pwm_in = 1'b0; wait_cyc(20);
    end
  endtask

  task automatic t_reset();
    wait_cyc(3);
    check("R9 flag in reset", lim_flag, 1);
    check("R3 hs in reset", hs_en, 0);
    check("R3 ls in reset", ls_en, 0);
    rst_n = 1'b1;
    pwm_in = 1'b1; sr_en = 1'b1;
    begin
      int hs_hi = 0;
      int fl_lo = 0;
      for (int i = 0; i < 12; i++) begin
        wait_cyc(1);
        if (hs_en || ls_en) hs_hi++;
        if (!lim_flag) fl_lo++;
      end
      check("R3 gates off without supply", hs_hi, 0);
      check("R9 flag held without supply", fl_lo, 0);
    end
    pwm_in = 1'b0; vdd_ok = 1'b1; reg_ok = 1'b1;
    wait_cyc(6);
    check("R9 flag drops when ready", lim_flag, 0);
    check("R2 low side on with PWM low", ls_en, 1);
  endtask

  task automatic t_deadtime(input int d);
    int gap;
    dead_cyc = 6'(d);
    wait_cyc(2);
    gap = 0;
    pwm_in = 1'b1;
    for (int i = 0; i < 60 && !hs_en; i++) begin
      wait_cyc(1);
      if (!hs_en && !ls_en) gap++;
    end
    check("R2 gap before high side", gap, d + 1);
    wait_cyc(5);
    gap = 0;
    pwm_in = 1'b0;
    for (int i = 0; i < 60 && !ls_en; i++) begin
      wait_cyc(1);
      if (!hs_en && !ls_en) gap++;
    end
    check("R2 gap before low side", gap, d + 1);
    wait_cyc(5);
  endtask

  task automatic t_sre_off();
    int ls_hi, hs_hi;
    sr_en = 1'b0;
    wait_cyc(4);
    ls_hi = 0; hs_hi = 0;
    repeat (2) begin
      pwm_in = 1'b1;
      repeat (15) begin wait_cyc(1); if (ls_en) ls_hi++; if (hs_en) hs_hi++; end
      pwm_in = 1'b0;
      repeat (15) begin wait_cyc(1); if (ls_en) ls_hi++; if (hs_en) hs_hi++; end
    end
    check("R1 low side held off", ls_hi, 0);
    check("R1 high side still switches", (hs_hi > 0) ? 1 : 0, 1);
    sr_en = 1'b1;
    wait_cyc(6);
    check("R1 low side back with enable", ls_en, 1);
  endtask

  task automatic t_trip_input();
    pwm_in = 1'b1; wait_cyc(12);
    check("R4 high side on before trip", hs_en, 1);
    cmp_in_oc = 1'b1; wait_cyc(3);
    check("R4 trip cuts high side", hs_en, 0);
    cmp_in_oc = 1'b0; wait_cyc(10);
    check("R4 high side stays off", hs_en, 0);
    check("R8 flag set by trip", lim_flag, 1);
    check("R5 low side after trip", ls_en, 1);
    pwm_in = 1'b0; wait_cyc(15);
    pwm_in = 1'b1; wait_cyc(10);
    check("R4 resumes on next rise", hs_en, 1);
    check("R8 flag kept through first rise", lim_flag, 1);
    pwm_in = 1'b0; wait_cyc(15);
    pwm_in = 1'b1; wait_cyc(10);
    check("R8 flag cleared after clean cycle", lim_flag, 0);
    pwm_in = 1'b0; wait_cyc(15);
  endtask

  task automatic t_trip_repeat();
    pwm_in = 1'b1; wait_cyc(12);
    cmp_out_oc = 1'b1; wait_cyc(1); cmp_out_oc = 1'b0;
    wait_cyc(8);
    pwm_in = 1'b0; wait_cyc(15);
    pwm_in = 1'b1; wait_cyc(12);
    cmp_out_oc = 1'b1; wait_cyc(1); cmp_out_oc = 1'b0;
    wait_cyc(8);
    check("R7 output trip cuts high side", hs_en, 0);
    pwm_in = 1'b0; wait_cyc(15);
    pwm_in = 1'b1; wait_cyc(10);
    check("R8 flag stays after faulty cycle", lim_flag, 1);
    pwm_in = 1'b0; wait_cyc(15);
    clean_cycles();
    check("R8 flag clears after recovery", lim_flag, 0);
  endtask

  task automatic t_blank_len(input int len, input int exp_flag);
    pwm_in = 1'b1; cmp_in_oc = 1'b1;
    wait_cyc(len);
    cmp_in_oc = 1'b0;
    wait_cyc(12);
    check($sformatf("R6 pulse of %0d at rise", len), lim_flag, exp_flag);
    check($sformatf("R6 high side after pulse %0d", len), hs_en, exp_flag ? 0 : 1);
    pwm_in = 1'b0; wait_cyc(15);
    if (exp_flag != 0) clean_cycles();
  endtask

  task automatic t_falling_edges();
    pwm_in = 1'b1; wait_cyc(15);
    pwm_in = 1'b0; cmp_out_oc = 1'b1; wait_cyc(2); cmp_out_oc = 1'b0;
    wait_cyc(6);
    check("R7 output comparator blanked at fall", lim_flag, 0);
    check("R7 low side unaffected", ls_en, 1);
    pwm_in = 1'b1; cmp_out_oc = 1'b1; wait_cyc(2); cmp_out_oc = 1'b0;
    wait_cyc(10);
    check("R7 output comparator blanked at rise", lim_flag, 0);
    pwm_in = 1'b0; cmp_in_oc = 1'b1; wait_cyc(2); cmp_in_oc = 1'b0;
    wait_cyc(6);
    check("R6 input comparator not blanked at fall", lim_flag, 1);
    check("R5 low side kept on trip while low", ls_en, 1);
    wait_cyc(10);
    clean_cycles();
    check("R8 flag clear before low trip", lim_flag, 0);
    wait_cyc(5);
    cmp_out_oc = 1'b1; wait_cyc(1); cmp_out_oc = 1'b0;
    wait_cyc(4);
    check("R5 low side held during low-phase trip", ls_en, 1);
    check("R8 low-phase trip sets flag", lim_flag, 1);
    clean_cycles();
  endtask

  task automatic t_supply_drop();
    pwm_in = 1'b1; wait_cyc(12);
    check("R3 high side on before drop", hs_en, 1);
    reg_ok = 1'b0; wait_cyc(2);
    check("R3 high side off on supply loss", hs_en, 0);
    check("R3 low side off on supply loss", ls_en, 0);
    check("R9 flag on supply loss", lim_flag, 1);
    pwm_in = 1'b0; wait_cyc(6);
    check("R3 low side off while supply lost", ls_en, 0);
    reg_ok = 1'b1; wait_cyc(4);
    check("R9 flag drops on supply return", lim_flag, 0);
    check("R2 low side resumes", ls_en, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_deadtime(2);
    t_deadtime(0);
    t_deadtime(5);
    dead_cyc = 6'd2;
    t_sre_off();
    t_trip_input();
    t_trip_repeat();
    t_blank_len(5, 0);
    t_blank_len(6, 1);
    t_falling_edges();
    t_supply_drop();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule